// File: doc/BRIEF.md
# Double Frame Buffer Controller

This block sits between a CPU bus and two frame-buffer memories. At any moment the display scans one buffer while the CPU reads and writes the other; a frame-select flag says which buffer the display owns, and the CPU is always steered to the opposite one. Software changes the flag by writing a select register. The change takes effect at once when the display is in vertical blank or when the display mode field is zero. Otherwise it is held as pending and applied when vertical blank begins, so a frame is never torn mid-scan.

The CPU address carries one bit above the buffer index that opens a second view of the same memory, the overwrite window. Writes through that window treat a zero byte as transparent: a zero byte leaves the stored pixel as it is. Byte writes of zero are simply dropped. Halfword writes go through a two-cycle read-modify-write: the old word is fetched while the CPU is stalled, then merged lane by lane with the new data and written back. Reads and writes through the normal window behave like plain memory. Scan-out and palette handling are outside this block; it only drives the memory ports of the two buffers and reports the select state.

Top module: `fbc_dual_buffer`

## Requirements
- R1: Every CPU access (read or write) goes to the buffer whose index is the inverse of `frame_sel`, sampled when the access starts; the enable of the other buffer stays low, and at most one buffer enable is high in any cycle.
- R2: A select-register write uses only bit 0 of `sel_wdata`; all other bits are ignored, and bit 0 becomes the pending select value.
- R3: When `sel_wr` is high in a cycle where `vblank` is high or `disp_mode` is zero, `frame_sel` takes bit 0 of the written data after that clock edge and `swap_pending` is low.
- R4: When `sel_wr` is high with `vblank` low and `disp_mode` non-zero, `frame_sel` keeps its value and `swap_pending` goes high; the held value is loaded into `frame_sel` at the first clock edge where `vblank` (or a zero `disp_mode`) is seen, and `swap_pending` then clears. `frame_sel` never changes otherwise.
- R5: `cpu_addr[17]` selects the overwrite window (1) or the normal window (0); `cpu_addr[16:1]` is the halfword index into the buffer and both windows reach the same words. For byte accesses `cpu_addr[0]` = 0 selects the upper lane (bits 15:8) and 1 the lower lane (bits 7:0).
- R6: In the normal window a byte write (`cpu_size` = 0) stores `cpu_wdata[7:0]` in the addressed lane only, and a halfword write (`cpu_size` = 1) stores all 16 bits; both finish in one cycle without stall.
- R7: In the overwrite window a byte write whose data is zero enables no memory and leaves the word unchanged; a non-zero byte write stores as in R6.
- R8: In the overwrite window a halfword write raises `cpu_stall` for exactly one cycle, then writes a word whose upper and lower bytes are each the new byte if it is non-zero, else the old stored byte.
- R9: For a read request, `cpu_rdata` holds the addressed halfword of the selected buffer from the cycle after the request, without stall.
- R10: After reset `frame_sel` is 0, `swap_pending` is 0, `cpu_stall` is 0 and both buffer enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 1 | 0 = byte, 1 = halfword |
| cpu_addr | input | ADDR_W+1 | Byte address; top bit selects overwrite window |
| cpu_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| cpu_rdata | output | 16 | Read data, one cycle after the request |
| cpu_stall | output | 1 | CPU must hold its request this cycle |
| sel_wr | input | 1 | Frame-select register write strobe |
| sel_wdata | input | SEL_W | Select register write data; bit 0 used |
| vblank | input | 1 | Vertical blank status |
| disp_mode | input | MODE_W | Display mode field; zero means display off |
| frame_sel | output | 1 | Buffer currently owned by the display |
| swap_pending | output | 1 | A select change is waiting for blanking |
| fb_en | output | 2 | Per-buffer memory enable |
| fb_be | output | 2x2 | Per-buffer byte write enables (bit 1 = upper byte) |
| fb_addr | output | 2x(ADDR_W-1) | Per-buffer halfword address |
| fb_wdata | output | 2x16 | Per-buffer write data |
| fb_rdata | input | 2x16 | Per-buffer read data, registered, one cycle after enable |

## Verification
The assertions assume that the CPU holds `cpu_req`, `cpu_we`, `cpu_size`, `cpu_addr` and `cpu_wdata` steady through a stalled cycle and that each memory returns read data one cycle after its enable, with a read issued whenever the byte enables are all low. The stimulus drives every input on the falling edge and keeps the request asserted, unchanged, across the stall of each overwrite halfword write, and the bench's memory model answers with a registered read of the pre-write contents. Select writes are issued only with no CPU request outstanding, so the buffer an access starts on is always the one the model predicts.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
   localparam int FB_DW   = 16;
   localparam int FB_LANE = 8;
   localparam int FB_NL   = FB_DW / FB_LANE;
   localparam int FB_NBUF = 2;

   localparam logic SZ_BYTE = 1'b0;
   localparam logic SZ_HALF = 1'b1;

   typedef enum logic {
      ACC_IDLE  = 1'b0,
      ACC_MERGE = 1'b1
   } acc_state_e;
endpackage

// File: rtl/fbc_select.sv
module fbc_select #(
   parameter int SEL_W  = 8,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr,
   input  logic [SEL_W-1:0]  sel_wdata,
   input  logic              vblank,
   input  logic [MODE_W-1:0] disp_mode,
   output logic              frame_sel,
   output logic              swap_pending
);
   logic may_swap;
   logic pend_val_q;
   logic sel_bit;
   logic sel_hi_unused;

   assign sel_bit       = sel_wdata[0];
   assign sel_hi_unused = ^sel_wdata;
   assign may_swap      = vblank || (disp_mode == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_sel    <= 1'b0;
         swap_pending <= 1'b0;
         pend_val_q   <= 1'b0;
      end else if (sel_wr) begin
         pend_val_q <= sel_bit;
         if (may_swap) begin
            frame_sel    <= sel_bit;
            swap_pending <= 1'b0;
         end else begin
            swap_pending <= 1'b1;
         end
      end else if (swap_pending && may_swap) begin
         frame_sel    <= pend_val_q;
         swap_pending <= 1'b0;
      end
   end
endmodule

// File: rtl/fbc_access.sv
module fbc_access
   import fbc_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter bit USE_RMW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic                cpu_size,
   input  logic [ADDR_W:0]     cpu_addr,
   input  logic [FB_DW-1:0]    cpu_wdata,
   input  logic                frame_sel,
   input  logic [FB_DW-1:0]    rd_word,
   output logic                acc_en,
   output logic [FB_NL-1:0]    acc_be,
   output logic [ADDR_W-2:0]   acc_addr,
   output logic [FB_DW-1:0]    acc_wdata,
   output logic                acc_buf,
   output logic                rd_buf_q,
   output logic                cpu_stall
);
   acc_state_e state_q, state_d;

   logic                 in_ow;
   logic                 lo_lane;
   logic [FB_LANE-1:0]   byte_val;
   logic [FB_NL-1:0]     lane_nz;
   logic [FB_DW-1:0]     merged;
   logic [FB_NL-1:0]     hw_ow_be;
   logic                 hw_ow_en;
   logic                 hw_ow_stall;

   assign in_ow    = cpu_addr[ADDR_W];
   assign lo_lane  = cpu_addr[0];
   assign byte_val = cpu_wdata[FB_LANE-1:0];

   for (genvar l = 0; l < FB_NL; l++) begin : g_lane
      assign lane_nz[l] = |cpu_wdata[l*FB_LANE +: FB_LANE];
      assign merged[l*FB_LANE +: FB_LANE] = lane_nz[l] ? cpu_wdata[l*FB_LANE +: FB_LANE]
                                                      : rd_word[l*FB_LANE +: FB_LANE];
   end

   if (USE_RMW) begin : g_rmw
      // read first, merge next cycle
      assign hw_ow_en    = 1'b1;
      assign hw_ow_be    = '0;
      assign hw_ow_stall = 1'b1;
   end else begin : g_mask
      // drop zero lanes with byte enables
      assign hw_ow_en    = |lane_nz;
      assign hw_ow_be    = lane_nz;
      assign hw_ow_stall = 1'b0;
   end

   always_comb begin
      state_d   = state_q;
      acc_buf   = (state_q == ACC_MERGE) ? rd_buf_q : ~frame_sel;
      acc_addr  = cpu_addr[ADDR_W-1:1];
      acc_en    = 1'b0;
      acc_be    = '0;
      acc_wdata = cpu_wdata;
      cpu_stall = 1'b0;
      if (state_q == ACC_MERGE) begin
         acc_en    = 1'b1;
         acc_be    = '1;
         acc_wdata = merged;
         state_d   = ACC_IDLE;
      end else if (cpu_req) begin
         if (!cpu_we) begin
            acc_en = 1'b1;
         end else if (cpu_size == SZ_BYTE) begin
            acc_wdata = {FB_NL{byte_val}};
            acc_be    = lo_lane ? FB_NL'(1) : FB_NL'(2);
            acc_en    = !(in_ow && (byte_val == '0));
         end else if (in_ow) begin
            acc_en    = hw_ow_en;
            acc_be    = hw_ow_be;
            cpu_stall = hw_ow_stall;
            if (hw_ow_stall) state_d = ACC_MERGE;
         end else begin
            acc_en = 1'b1;
            acc_be = '1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ACC_IDLE;
         rd_buf_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (acc_en && (acc_be == '0)) rd_buf_q <= acc_buf;
      end
   end
endmodule

// File: rtl/fbc_port_mux.sv
module fbc_port_mux
   import fbc_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic                                  acc_en,
   input  logic [FB_NL-1:0]                      acc_be,
   input  logic [ADDR_W-2:0]                     acc_addr,
   input  logic [FB_DW-1:0]                      acc_wdata,
   input  logic                                  acc_buf,
   input  logic                                  rd_buf_q,
   input  logic [FB_NBUF-1:0][FB_DW-1:0]         fb_rdata,
   output logic [FB_NBUF-1:0]                    fb_en,
   output logic [FB_NBUF-1:0][FB_NL-1:0]         fb_be,
   output logic [FB_NBUF-1:0][ADDR_W-2:0]        fb_addr,
   output logic [FB_NBUF-1:0][FB_DW-1:0]         fb_wdata,
   output logic [FB_DW-1:0]                      rd_word
);
   for (genvar b = 0; b < FB_NBUF; b++) begin : g_buf
      assign fb_en[b]    = acc_en && (acc_buf == 1'(b));
      assign fb_be[b]    = fb_en[b] ? acc_be : '0;
      assign fb_addr[b]  = acc_addr;
      assign fb_wdata[b] = acc_wdata;
   end

   assign rd_word = fb_rdata[rd_buf_q];
endmodule

// File: rtl/fbc_dual_buffer.sv
module fbc_dual_buffer
   import fbc_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int SEL_W   = 8,
   parameter int MODE_W  = 2,
   parameter bit USE_RMW = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cpu_req,
   input  logic                                  cpu_we,
   input  logic                                  cpu_size,
   input  logic [ADDR_W:0]                       cpu_addr,
   input  logic [FB_DW-1:0]                      cpu_wdata,
   output logic [FB_DW-1:0]                      cpu_rdata,
   output logic                                  cpu_stall,
   input  logic                                  sel_wr,
   input  logic [SEL_W-1:0]                      sel_wdata,
   input  logic                                  vblank,
   input  logic [MODE_W-1:0]                     disp_mode,
   output logic                                  frame_sel,
   output logic                                  swap_pending,
   output logic [FB_NBUF-1:0]                    fb_en,
   output logic [FB_NBUF-1:0][FB_NL-1:0]         fb_be,
   output logic [FB_NBUF-1:0][ADDR_W-2:0]        fb_addr,
   output logic [FB_NBUF-1:0][FB_DW-1:0]         fb_wdata,
   input  logic [FB_NBUF-1:0][FB_DW-1:0]         fb_rdata
);
   if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addr_w
      $error("fbc_dual_buffer: ADDR_W must be within 2..30");
   end
   if (SEL_W < 1) begin : g_bad_sel_w
      $error("fbc_dual_buffer: SEL_W must be at least 1");
   end
   if (MODE_W < 1) begin : g_bad_mode_w
      $error("fbc_dual_buffer: MODE_W must be at least 1");
   end

   logic                 acc_en;
   logic [FB_NL-1:0]     acc_be;
   logic [ADDR_W-2:0]    acc_addr;
   logic [FB_DW-1:0]     acc_wdata;
   logic                 acc_buf;
   logic                 rd_buf_q;
   logic [FB_DW-1:0]     rd_word;

   fbc_select #(.SEL_W(SEL_W), .MODE_W(MODE_W)) u_select (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_wr       (sel_wr),
      .sel_wdata    (sel_wdata),
      .vblank       (vblank),
      .disp_mode    (disp_mode),
      .frame_sel    (frame_sel),
      .swap_pending (swap_pending)
   );

   fbc_access #(.ADDR_W(ADDR_W), .USE_RMW(USE_RMW)) u_access (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_size  (cpu_size),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .frame_sel (frame_sel),
      .rd_word   (rd_word),
      .acc_en    (acc_en),
      .acc_be    (acc_be),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_buf   (acc_buf),
      .rd_buf_q  (rd_buf_q),
      .cpu_stall (cpu_stall)
   );

   fbc_port_mux #(.ADDR_W(ADDR_W)) u_port_mux (
      .acc_en    (acc_en),
      .acc_be    (acc_be),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_buf   (acc_buf),
      .rd_buf_q  (rd_buf_q),
      .fb_rdata  (fb_rdata),
      .fb_en     (fb_en),
      .fb_be     (fb_be),
      .fb_addr   (fb_addr),
      .fb_wdata  (fb_wdata),
      .rd_word   (rd_word)
   );

   assign cpu_rdata = rd_word;
endmodule

// File: rtl/fbc_dual_buffer_chk.sv
module fbc_dual_buffer_chk #(
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_size,
   input logic              in_ow,
   input logic [7:0]        wlow,
   input logic              cpu_stall,
   input logic              sel_wr,
   input logic              vblank,
   input logic [MODE_W-1:0] disp_mode,
   input logic              frame_sel,
   input logic              swap_pending,
   input logic [1:0]        fb_en
);
   // R1
   one_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fb_en));

   // R1
   cpu_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_en != 2'b00) && !$past(cpu_stall) |-> !fb_en[frame_sel]);

   // R4
   pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr && !vblank && (disp_mode != '0) |=> swap_pending);

   // R4
   pending_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap_pending && !sel_wr && vblank |=> !swap_pending);

   // R4
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr && !swap_pending |=> $stable(frame_sel));

   // R7
   zero_byte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && !cpu_size && in_ow && (wlow == 8'h00) && !$past(cpu_stall)
      |-> (fb_en == 2'b00));

   // R8
   single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |=> !cpu_stall && $onehot(fb_en));
endmodule

bind fbc_dual_buffer fbc_dual_buffer_chk #(.MODE_W(MODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_req      (cpu_req),
   .cpu_we       (cpu_we),
   .cpu_size     (cpu_size),
   .in_ow        (cpu_addr[ADDR_W]),
   .wlow         (cpu_wdata[7:0]),
   .cpu_stall    (cpu_stall),
   .sel_wr       (sel_wr),
   .vblank       (vblank),
   .disp_mode    (disp_mode),
   .frame_sel    (frame_sel),
   .swap_pending (swap_pending),
   .fb_en        (fb_en)
);

// File: tb/fbc_dual_buffer_bench.sv
`timescale 1ns/1ps
module fbc_dual_buffer_bench;
   localparam int AW = 17;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic              cpu_size = 1'b0;
   logic [AW:0]       cpu_addr = '0;
   logic [15:0]       cpu_wdata = '0;
   logic [15:0]       cpu_rdata;
   logic              cpu_stall;
   logic              sel_wr = 1'b0;
   logic [7:0]        sel_wdata = '0;
   logic              vblank = 1'b0;
   logic [1:0]        disp_mode = 2'd1;
   logic              frame_sel;
   logic              swap_pending;
   logic [1:0]        fb_en;
   logic [1:0][1:0]   fb_be;
   logic [1:0][AW-2:0] fb_addr;
   logic [1:0][15:0]  fb_wdata;
   logic [1:0][15:0]  fb_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   fbc_dual_buffer u_fbc_dual_buffer (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .vblank(vblank), .disp_mode(disp_mode),
      .frame_sel(frame_sel), .swap_pending(swap_pending), .fb_en(fb_en), .fb_be(fb_be),
      .fb_addr(fb_addr), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata)
   );

   // environment memories behind the ports
   logic [15:0] env0 [int];
   logic [15:0] env1 [int];
   // reference model contents
   logic [15:0] ref0 [int];
   logic [15:0] ref1 [int];

   function automatic logic [15:0] env_get(bit b, int w);
      if (b == 1'b0) return env0.exists(w) ? env0[w] : 16'h0000;
      return env1.exists(w) ? env1[w] : 16'h0000;
   endfunction

   function automatic logic [15:0] ref_get(bit b, int w);
      if (b == 1'b0) return ref0.exists(w) ? ref0[w] : 16'h0000;
      return ref1.exists(w) ? ref1[w] : 16'h0000;
   endfunction

   function automatic void ref_put(bit b, int w, logic [15:0] v);
      if (b == 1'b0) ref0[w] = v;
      else ref1[w] = v;
   endfunction

   always @(posedge clk) begin
      for (int b = 0; b < 2; b++) begin
         if (fb_en[b]) begin
            logic [15:0] old_w, new_w;
            old_w = env_get(b[0], int'(fb_addr[b]));
            new_w = old_w;
            if (fb_be[b][1]) new_w[15:8] = fb_wdata[b][15:8];
            if (fb_be[b][0]) new_w[7:0]  = fb_wdata[b][7:0];
            fb_rdata[b] <= old_w;
            if (b == 0) env0[int'(fb_addr[b])] = new_w;
            else        env1[int'(fb_addr[b])] = new_w;
         end
      end
   end

   // select model state
   bit m_fs = 0, m_pend = 0, m_pv = 0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic tick();
      bit may;
      may = vblank || (disp_mode == 2'd0);
      if (sel_wr) begin
         m_pv = sel_wdata[0];
         if (may) begin m_fs = sel_wdata[0]; m_pend = 0; end
         else m_pend = 1;
      end else if (m_pend && may) begin
         m_fs = m_pv; m_pend = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk("R4 frame_sel", 32'(frame_sel), 32'(m_fs));
      chk("R4 swap_pending", 32'(swap_pending), 32'(m_pend));
   endtask

   task automatic sel_write(logic [7:0] d);
      sel_wr = 1'b1; sel_wdata = d;
      tick();
      sel_wr = 1'b0; sel_wdata = '0;
   endtask

   task automatic cpu_wr(bit ow, bit half, logic [16:0] a, logic [15:0] d, string tag);
      bit b;
      int w;
      logic [15:0] old_w, new_w;
      b = !m_fs;
      w = int'(a[16:1]);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = half; cpu_addr = {ow, a}; cpu_wdata = d;
      #1;
      old_w = ref_get(b, w);
      new_w = old_w;
      if (!half) begin
         bit en;
         en = !(ow && d[7:0] == 8'h00);
         chk({tag, " R6 byte no stall"}, 32'(cpu_stall), 32'd0);
         chk({tag, " R1 byte enable"}, 32'(fb_en), en ? (32'd1 << b) : 32'd0);
         if (en) begin
            if (a[0]) new_w[7:0] = d[7:0];
            else new_w[15:8] = d[7:0];
         end
         tick();
      end else if (!ow) begin
         chk({tag, " R6 half no stall"}, 32'(cpu_stall), 32'd0);
         chk({tag, " R1 half enable"}, 32'(fb_en), 32'd1 << b);
         new_w = d;
         tick();
      end else begin
         chk({tag, " R8 stall first cycle"}, 32'(cpu_stall), 32'd1);
         chk({tag, " R1 rmw read enable"}, 32'(fb_en), 32'd1 << b);
         tick();
         #1;
         chk({tag, " R8 stall released"}, 32'(cpu_stall), 32'd0);
         chk({tag, " R8 merge enable"}, 32'(fb_en), 32'd1 << b);
         if (d[15:8] != 8'h00) new_w[15:8] = d[15:8];
         if (d[7:0]  != 8'h00) new_w[7:0]  = d[7:0];
         tick();
      end
      ref_put(b, w, new_w);
      cpu_req = 1'b0; cpu_we = 1'b0;
      chk({tag, " memory word"}, 32'(env_get(b, w)), 32'(new_w));
   endtask

   task automatic cpu_rd(logic [16:0] a, string tag);
      bit b;
      b = !m_fs;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 1'b1; cpu_addr = {1'b0, a};
      #1;
      chk({tag, " R9 read no stall"}, 32'(cpu_stall), 32'd0);
      chk({tag, " R1 read enable"}, 32'(fb_en), 32'd1 << b);
      tick();
      chk({tag, " R9 read data"}, 32'(cpu_rdata), 32'(ref_get(b, int'(a[16:1]))));
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      chk("R10 frame_sel", 32'(frame_sel), 32'd0);
      chk("R10 swap_pending", 32'(swap_pending), 32'd0);
      chk("R10 stall", 32'(cpu_stall), 32'd0);
      chk("R10 enables", 32'(fb_en), 32'd0);
      tick();

      // normal window, buffer 1 seen by CPU
      cpu_wr(0, 1, 17'h00010, 16'h1234, "R6 half");
      cpu_rd(17'h00010, "R9");
      cpu_wr(0, 0, 17'h00021, 16'h00AA, "R5 low lane");
      cpu_wr(0, 0, 17'h00020, 16'h00BB, "R5 high lane");
      cpu_rd(17'h00020, "R5");

      // immediate swaps in blanking (R2, R3)
      vblank = 1'b1;
      sel_write(8'hFE);
      chk("R2 upper bits ignored", 32'(frame_sel), 32'd0);
      sel_write(8'h03);
      chk("R3 swap in vblank", 32'(frame_sel), 32'd1);
      vblank = 1'b0;
      tick();
      cpu_rd(17'h00010, "R1 other buffer");
      cpu_wr(0, 1, 17'h00010, 16'hCAFE, "R1 buffer0");

      // deferred swap (R4)
      sel_write(8'h02);
      chk("R4 pending set", 32'(swap_pending), 32'd1);
      tick(); tick(); tick();
      cpu_rd(17'h00010, "R4 still old buffer");
      vblank = 1'b1;
      tick();
      chk("R4 applied at vblank", 32'(frame_sel), 32'd0);
      vblank = 1'b0;
      tick();

      // display off swaps at once (R3)
      disp_mode = 2'd0;
      sel_write(8'h01);
      chk("R3 mode zero swap", 32'(frame_sel), 32'd1);
      sel_write(8'h00);
      disp_mode = 2'd2;
      tick();

      // overwrite window bytes (R7)
      cpu_wr(1, 0, 17'h00021, 16'hFF00, "R7 zero byte");
      cpu_rd(17'h00020, "R7");
      cpu_wr(1, 0, 17'h00020, 16'h0077, "R7 nonzero byte");
      cpu_rd(17'h00020, "R7");

      // overwrite window halfwords (R8)
      cpu_wr(1, 1, 17'h00010, 16'h00AB, "R8 low only");
      cpu_rd(17'h00010, "R8");
      cpu_wr(1, 1, 17'h00010, 16'hCD00, "R8 high only");
      cpu_wr(1, 1, 17'h00010, 16'h0000, "R8 all zero");
      cpu_rd(17'h00010, "R8");
      cpu_wr(1, 1, 17'h00010, 16'h5566, "R8 both");
      cpu_rd(17'h00010, "R5 alias");

      // pending swap with another write overriding it (R2, R4)
      sel_write(8'hFF);
      sel_write(8'h00);
      chk("R4 pending overridden", 32'(swap_pending), 32'd1);
      vblank = 1'b1;
      tick();
      chk("R2 last pending value", 32'(frame_sel), 32'd0);
      vblank = 1'b0;
      cpu_rd(17'h00010, "R1 final");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule